// File: doc/BRIEF.md
# Real-Time Counter with Wakeup Interval Timer

This peripheral keeps a 32-bit free-running count on a slow counter clock and raises a wakeup interrupt once a programmed number of counter ticks has passed. Software sees three 32-bit registers on a simple bus running on the system clock:

- A control word selects one of four counter clock sources and sets the prescaler. The prescaler has two stages, divide-by-512 and divide-by-32. Either stage can be used alone, or both can be chained.
- A status word carries the wakeup flag and a busy indication.
- An interval word holds the number of prescaled ticks to wait.

The counter, prescaler and interval compare all run on the selected source clock. The interval value is handed from the bus clock into the counter clock with a toggle request and acknowledge. While that transfer is open, the busy bit reads 1. When the compare matches, a toggle event returns to the bus clock and sets the flag. The interrupt output is the flag gated by the interrupt enable. After each match the compare re-arms from the match point, so the flag fires periodically until software writes an interval of zero.

The clock source and divider fields must only be changed while the run bit is 0. Software clears run, writes the new configuration, then sets run again. The source code 1 is reserved and never clocks the counter domain.

Top module: `rtc_wake`

## Requirements
- R1: After reset, control, status and interval all read 0 and `irq` is 0.
- R2: Control keeps run (bit 31), interval enable (bit 15), interrupt enable (bit 14), source select (bits 13:12), divide-by-512 enable (bit 11) and divide-by-32 enable (bit 10). All other control bits read 0. Writing all ones reads back 0x8000FC00. The interval register reads back the last value written. Offsets other than 0x4 (control), 0x8 (status) and 0x10 (interval) read 0 and ignore writes.
- R3: With run, interval enable and a nonzero interval N set and no divider enabled, status bit 13 sets N source-clock ticks after the interval value takes effect.
- R4: Divide-by-32 alone gives one tick per 32 source edges. Divide-by-512 alone gives one tick per 512 edges. Both together give one tick per 16384 edges.
- R5: Status bit 17 reads 1 from the cycle after an interval write until the value has been taken into the counter domain, and then reads 0.
- R6: Writing status with bit 13 = 1 clears the flag. Writing it with bit 13 = 0 leaves the flag unchanged.
- R7: `irq` equals status bit 13 ANDed with control bit 14.
- R8: An interval value of 0 disarms the timer, so the flag never sets.
- R9: With source select 1 (reserved), no counting occurs and an interval write stays busy. Selecting a valid source afterwards completes the transfer.
- R10: With run = 0, or with interval enable = 0, the flag does not set.
- R11: After a match, the timer re-arms and matches again N ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus/system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 4 | Candidate counter clocks, index = source code |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| irq | output | 1 | Wakeup interrupt request |

## Verification
The bound checker watches the bus-clock side on every cycle:
- an interval write always raises busy on the next cycle;
- the flag is set by a returned match event;
- the write-one-to-clear rule holds in both directions;
- unmapped writes never disturb control.

Cross-domain timing can only be shown by the bench's scenarios: the number of source edges from an interval write to the flag under each divider setting, periodic re-arming, the reserved source stalling the transfer, and disarming by zero or by cleared enables. The bench checks these against edge-count windows derived from the synchronizer depth.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned N_SRC  = 4;
  localparam int unsigned SRC_W  = $clog2(N_SRC);

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_IVAL = 5'h10;

  localparam int unsigned CB_RUN  = 31;
  localparam int unsigned CB_ARM  = 15;
  localparam int unsigned CB_IE   = 14;
  localparam int unsigned CB_SRC  = 12;
  localparam int unsigned CB_DIVA = 11;
  localparam int unsigned CB_DIVB = 10;
  localparam int unsigned SB_BUSY = 17;
  localparam int unsigned SB_FLAG = 13;

  typedef struct packed {
    logic             run;
    logic             arm;
    logic             ie;
    logic [SRC_W-1:0] src;
    logic             div_a;
    logic             div_b;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CB_RUN]                 = c.run;
    w[CB_ARM]                 = c.arm;
    w[CB_IE]                  = c.ie;
    w[CB_SRC +: SRC_W]        = c.src;
    w[CB_DIVA]                = c.div_a;
    w[CB_DIVB]                = c.div_b;
    return w;
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] w);
    ctrl_t c;
    c.run   = w[CB_RUN];
    c.arm   = w[CB_ARM];
    c.ie    = w[CB_IE];
    c.src   = w[CB_SRC +: SRC_W];
    c.div_a = w[CB_DIVA];
    c.div_b = w[CB_DIVB];
    return c;
  endfunction
endpackage

// File: rtl/rtc_wake_sync.sv
// Multi-stage level synchronizer; with d tied high it also serves as a
// reset release synchronizer.
module rtc_wake_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_n;

  always_comb sr_n = {sr_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_n;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/rtc_wake_presc.sv
// Two chainable power-of-two prescaler stages on the counter clock.
module rtc_wake_presc #(
  parameter int unsigned A_LOG2 = 9,
  parameter int unsigned B_LOG2 = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic div_a,
  input  logic div_b,
  output logic tick
);
  logic [A_LOG2-1:0] ca_q, ca_n;
  logic [B_LOG2-1:0] cb_q, cb_n;
  logic              step_a, step_b;

  always_comb begin
    step_a = div_a ? (ca_q == '1) : 1'b1;
    step_b = div_b ? (cb_q == '1) : 1'b1;
    tick   = en & step_a & step_b;
    ca_n   = ca_q;
    cb_n   = cb_q;
    if (!en) begin
      ca_n = '0;
      cb_n = '0;
    end else begin
      if (div_a)           ca_n = ca_q + 1'b1;
      if (step_a && div_b) cb_n = cb_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_q <= '0;
      cb_q <= '0;
    end else begin
      ca_q <= ca_n;
      cb_q <= cb_n;
    end
  end
endmodule

// File: rtl/rtc_wake_core.sv
// Counter-clock domain: prescaler, free-running count, interval compare,
// receiving side of the interval handshake, sending side of match events.
module rtc_wake_core
  import rtc_wake_pkg::*;
#(
  parameter int unsigned A_LOG2      = 9,
  parameter int unsigned B_LOG2      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_a,
  input  logic              arm_a,
  input  logic              div_a,
  input  logic              div_b,
  input  logic              req_a,
  input  logic [DATA_W-1:0] xfer,
  output logic              ack_t,
  output logic              hit_t
);
  logic run_s, arm_s, req_s;
  logic tick;

  rtc_wake_sync #(.STAGES(SYNC_STAGES)) u_run (.clk(clk), .rst_n(rst_n), .d(run_a), .q(run_s));
  rtc_wake_sync #(.STAGES(SYNC_STAGES)) u_arm (.clk(clk), .rst_n(rst_n), .d(arm_a), .q(arm_s));
  rtc_wake_sync #(.STAGES(SYNC_STAGES)) u_req (.clk(clk), .rst_n(rst_n), .d(req_a), .q(req_s));

  rtc_wake_presc #(.A_LOG2(A_LOG2), .B_LOG2(B_LOG2)) u_presc (
    .clk(clk), .rst_n(rst_n), .en(run_s), .div_a(div_a), .div_b(div_b), .tick(tick)
  );

  logic              req_d_q;
  logic [DATA_W-1:0] ival_c_q, ival_c_n;
  logic [DATA_W-1:0] cnt_q, cnt_n;
  logic [DATA_W-1:0] base_q, base_n;
  logic              hit_q, hit_n;
  logic              new_val, hit;

  always_comb begin
    new_val  = req_s ^ req_d_q;
    cnt_n    = tick ? cnt_q + 1'b1 : cnt_q;
    ival_c_n = new_val ? xfer : ival_c_q;
    hit      = tick & arm_s & (ival_c_q != '0) & ~new_val &
               ((cnt_n - base_q) == ival_c_q);
    base_n   = (new_val | ~arm_s | hit) ? cnt_n : base_q;
    hit_n    = hit_q ^ hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d_q  <= 1'b0;
      ival_c_q <= '0;
      cnt_q    <= '0;
      base_q   <= '0;
      hit_q    <= 1'b0;
    end else begin
      req_d_q  <= req_s;
      if (new_val) ival_c_q <= ival_c_n;
      if (tick)    cnt_q    <= cnt_n;
      base_q   <= base_n;
      hit_q    <= hit_n;
    end
  end

  assign ack_t = req_d_q;
  assign hit_t = hit_q;
endmodule

// File: rtl/rtc_wake_regs.sv
// Bus-clock domain register file, interval transfer launch and flag.
module rtc_wake_regs
  import rtc_wake_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] xfer,
  output logic              req_t,
  input  logic              ack_t,
  input  logic              hit_t,
  output logic              flag,
  output logic              flag_set,
  output logic              busy
);
  logic ack_s, hit_s;

  rtc_wake_sync #(.STAGES(SYNC_STAGES)) u_ack (.clk(clk), .rst_n(rst_n), .d(ack_t), .q(ack_s));
  rtc_wake_sync #(.STAGES(SYNC_STAGES)) u_hit (.clk(clk), .rst_n(rst_n), .d(hit_t), .q(hit_s));

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] ival_q, xfer_q, xfer_n;
  logic              req_q, req_n, pend_q, pend_n;
  logic              hit_d_q, flag_q, flag_n;
  logic              wr_ctrl, wr_stat, wr_ival, hs_busy;

  always_comb begin
    wr_ctrl  = bus_sel & bus_wr & (bus_addr == OFS_CTRL);
    wr_stat  = bus_sel & bus_wr & (bus_addr == OFS_STAT);
    wr_ival  = bus_sel & bus_wr & (bus_addr == OFS_IVAL);
    hs_busy  = req_q ^ ack_s;
    flag_set = hit_s ^ hit_d_q;
    xfer_n   = xfer_q;
    req_n    = req_q;
    pend_n   = pend_q;
    if (wr_ival) begin
      if (!hs_busy) begin
        xfer_n = bus_wdata;
        req_n  = ~req_q;
        pend_n = 1'b0;
      end else begin
        pend_n = 1'b1;
      end
    end else if (pend_q && !hs_busy) begin
      xfer_n = ival_q;
      req_n  = ~req_q;
      pend_n = 1'b0;
    end
    flag_n = flag_q;
    if (wr_stat && bus_wdata[SB_FLAG]) flag_n = 1'b0;
    if (flag_set)                      flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ival_q  <= '0;
      xfer_q  <= '0;
      req_q   <= 1'b0;
      pend_q  <= 1'b0;
      hit_d_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_unpack(bus_wdata);
      if (wr_ival) ival_q <= bus_wdata;
      xfer_q  <= xfer_n;
      req_q   <= req_n;
      pend_q  <= pend_n;
      hit_d_q <= hit_s;
      flag_q  <= flag_n;
    end
  end

  assign busy = hs_busy | pend_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        OFS_CTRL: bus_rdata = ctrl_pack(ctrl_q);
        OFS_STAT: begin
          bus_rdata[SB_BUSY] = busy;
          bus_rdata[SB_FLAG] = flag_q;
        end
        OFS_IVAL: bus_rdata = ival_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign ctrl  = ctrl_q;
  assign xfer  = xfer_q;
  assign req_t = req_q;
  assign flag  = flag_q;
endmodule

// File: rtl/rtc_wake.sv
module rtc_wake
  import rtc_wake_pkg::*;
#(
  parameter logic [N_SRC-1:0] RSVD_MASK   = 4'b0010,
  parameter int unsigned      PRE_A_LOG2  = 9,
  parameter int unsigned      PRE_B_LOG2  = 5,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_clk,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] xfer;
  logic              req_t, ack_t, hit_t;
  logic              flag, flag_set, busy;
  logic [N_SRC-1:0]  src_gate;
  logic              cnt_clk, rst_c_n;

  rtc_wake_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctrl(ctrl), .xfer(xfer), .req_t(req_t), .ack_t(ack_t), .hit_t(hit_t),
    .flag(flag), .flag_set(flag_set), .busy(busy)
  );

  // Source selection; reserved codes contribute a constant-low clock.
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (RSVD_MASK[i]) begin : g_rsvd
      assign src_gate[i] = 1'b0;
    end else begin : g_use
      assign src_gate[i] = src_clk[i] & (ctrl.src == SRC_W'(i));
    end
  end
  assign cnt_clk = |src_gate;

  rtc_wake_sync #(.STAGES(SYNC_STAGES)) u_rst_c (
    .clk(cnt_clk), .rst_n(rst_n), .d(1'b1), .q(rst_c_n)
  );

  rtc_wake_core #(
    .A_LOG2(PRE_A_LOG2), .B_LOG2(PRE_B_LOG2), .SYNC_STAGES(SYNC_STAGES)
  ) u_core (
    .clk(cnt_clk), .rst_n(rst_c_n),
    .run_a(ctrl.run), .arm_a(ctrl.arm), .div_a(ctrl.div_a), .div_b(ctrl.div_b),
    .req_a(req_t), .xfer(xfer), .ack_t(ack_t), .hit_t(hit_t)
  );

  assign irq = flag & ctrl.ie;
endmodule

// File: rtl/rtc_wake_chk.sv
module rtc_wake_chk
  import rtc_wake_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input ctrl_t             ctrl,
  input logic              flag,
  input logic              flag_set,
  input logic              busy
);
  logic wr_any, mapped;
  assign wr_any = bus_sel & bus_wr;
  assign mapped = (bus_addr == OFS_CTRL) | (bus_addr == OFS_STAT) | (bus_addr == OFS_IVAL);

  // R5
  ival_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == OFS_IVAL) |=> busy);

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == OFS_STAT && bus_wdata[SB_FLAG] && !flag_set) |=> !flag);

  // R6
  w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == OFS_STAT && !bus_wdata[SB_FLAG] && flag) |=> flag);

  // R3
  flag_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> flag);

  // R2
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !mapped) |=> $stable(ctrl));
endmodule

bind rtc_wake rtc_wake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ctrl(ctrl),
  .flag(flag), .flag_set(flag_set), .busy(busy)
);

// File: tb/rtc_wake_test.sv
`timescale 1ns/1ps
module rtc_wake_test;
  logic        clk, rst_n;
  logic [3:0]  src_clk;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  localparam logic [4:0] A_CTRL = 5'h04, A_STAT = 5'h08, A_IVAL = 5'h10;
  localparam logic [31:0] RUN = 32'h8000_0000, ARM = 32'h0000_8000, IE = 32'h0000_4000;
  localparam logic [31:0] D512 = 32'h0000_0800, D32 = 32'h0000_0400;
  localparam int BUSY_B = 17, FLAG_B = 13;

  rtc_wake uut (.*);

  initial clk = 0;
  always #2 clk = ~clk;
  initial src_clk = 4'b0;
  always #5 src_clk[0] = ~src_clk[0];
  always #4 src_clk[1] = ~src_clk[1];
  always #3 src_clk[2] = ~src_clk[2];
  always #7 src_clk[3] = ~src_clk[3];

  int edges [4];
  initial foreach (edges[i]) edges[i] = 0;
  always @(posedge src_clk[0]) edges[0]++;
  always @(posedge src_clk[1]) edges[1]++;
  always @(posedge src_clk[2]) edges[2]++;
  always @(posedge src_clk[3]) edges[3]++;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000 && !done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: run hung, act cycles=%0d exp <190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0d (0x%0h) exp=%0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Poll until the flag sets; returns 1 on success.
  task automatic wait_flag(input int limit, output bit seen);
    logic [31:0] s;
    seen = 0;
    for (int k = 0; k < limit; k++) begin
      rd(A_STAT, s);
      if (s[FLAG_B]) begin seen = 1; break; end
    end
  endtask

  task automatic wait_idle(input int limit, output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int k = 0; k < limit; k++) begin
      rd(A_STAT, s);
      if (!s[BUSY_B]) begin ok = 1; break; end
    end
  endtask

  task automatic disarm();
    bit ok;
    wr(A_IVAL, 0); wait_idle(2000, ok);
    wr(A_CTRL, 0); idle(20);
    wr(A_STAT, 32'h1 << FLAG_B);
  endtask

  // Measure source edges from interval write to flag; window checks R3/R4.
  task automatic timed(input int s, input logic [31:0] cfg, input int n, input int div,
                       input string req, input int limit);
    int e0, e, lo, hi; bit seen;
    wr(A_CTRL, cfg & ~RUN);
    wr(A_CTRL, cfg);
    idle(10);
    wr(A_IVAL, n);
    e0 = edges[s];
    wait_flag(limit, seen);
    e = edges[s] - e0;
    lo = (n - 1) * div + 1; hi = n * div + 8;
    chk(seen, req, "flag set", seen, 1);
    chk(e >= lo && e <= hi, req, "edges to flag", e, n * div);
  endtask

  logic [31:0] r;
  bit ok, seen;
  int t1, e2;

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    idle(5); #1 rst_n = 1; idle(5);

    // R1 reset state
    rd(A_CTRL, r); chk(r == 0, "R1", "ctrl after reset", r, 0);
    rd(A_STAT, r); chk(r == 0, "R1", "status after reset", r, 0);
    rd(A_IVAL, r); chk(r == 0, "R1", "interval after reset", r, 0);
    chk(irq == 0, "R1", "irq after reset", irq, 0);

    // R2 readback and unmapped offsets
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, r); chk(r == 32'h8000_FC00, "R2", "ctrl mask", r, 32'h8000_FC00);
    wr(A_CTRL, 32'h0);
    wr(A_IVAL, 32'h1234_5678);
    rd(A_IVAL, r); chk(r == 32'h1234_5678, "R2", "interval readback", r, 32'h1234_5678);
    wr(A_CTRL, ARM);
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h00, 32'hFFFF_FFFF);
    rd(A_CTRL, r); chk(r == ARM, "R2", "ctrl after unmapped writes", r, ARM);
    rd(5'h0C, r); chk(r == 0, "R2", "unmapped 0x0C reads 0", r, 0);
    rd(5'h00, r); chk(r == 0, "R2", "unmapped 0x00 reads 0", r, 0);
    wr(A_CTRL, 0); wait_idle(2000, ok); wr(A_IVAL, 0); wait_idle(2000, ok);

    // R3 / R5 / R7 divide-by-1 on source 0
    wr(A_CTRL, ARM | IE); wr(A_CTRL, RUN | ARM | IE); idle(10);
    wr(A_IVAL, 20);
    t1 = edges[0];
    rd(A_STAT, r); chk(r[BUSY_B] == 1, "R5", "busy after interval write", r[BUSY_B], 1);
    wait_idle(200, ok); chk(ok, "R5", "busy clears", ok, 1);
    wait_flag(500, seen);
    e2 = edges[0] - t1;
    chk(seen, "R3", "flag set div1", seen, 1);
    chk(e2 >= 20 && e2 <= 28, "R3", "edges to flag div1", e2, 20);
    chk(irq == 1, "R7", "irq with flag and enable", irq, 1);

    // R11 periodic re-arm
    t1 = edges[0];
    wr(A_STAT, 32'h1 << FLAG_B);
    wait_flag(500, seen);
    e2 = edges[0] - t1;
    chk(seen && e2 >= 16 && e2 <= 24, "R11", "second match period", e2, 20);

    // R7 interrupt gating
    wr(A_CTRL, RUN | ARM);
    #1 chk(irq == 0, "R7", "irq masked by enable", irq, 0);

    // R6 / R8 disarm with zero, then write-one-to-clear
    wr(A_IVAL, 0); wait_idle(200, ok); idle(20);
    rd(A_STAT, r); chk(r[FLAG_B] == 1, "R6", "flag still set", r[FLAG_B], 1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, r); chk(r[FLAG_B] == 1, "R6", "write 0 keeps flag", r[FLAG_B], 1);
    wr(A_STAT, 32'h1 << FLAG_B);
    rd(A_STAT, r); chk(r[FLAG_B] == 0, "R6", "write 1 clears flag", r[FLAG_B], 0);
    idle(200);
    rd(A_STAT, r); chk(r[FLAG_B] == 0, "R8", "zero interval never fires", r[FLAG_B], 0);
    disarm();

    // R4 prescaler ratios
    timed(2, RUN | ARM | IE | (32'd2 << 12) | D32, 4, 32, "R4", 2000);
    disarm();
    timed(3, RUN | ARM | IE | (32'd3 << 12) | D512, 2, 512, "R4", 8000);
    disarm();
    timed(2, RUN | ARM | IE | (32'd2 << 12) | D512 | D32, 2, 16384, "R4", 60000);
    disarm();

    // R10 run off, or interval enable off
    wr(A_CTRL, ARM | IE);
    wr(A_IVAL, 5); wait_idle(200, ok);
    idle(200);
    rd(A_STAT, r); chk(r[FLAG_B] == 0, "R10", "no flag with run off", r[FLAG_B], 0);
    wr(A_CTRL, RUN | IE);
    idle(200);
    rd(A_STAT, r); chk(r[FLAG_B] == 0, "R10", "no flag with interval enable off", r[FLAG_B], 0);
    disarm();

    // R9 reserved source
    wr(A_CTRL, ARM | IE | (32'd1 << 12));
    wr(A_CTRL, RUN | ARM | IE | (32'd1 << 12));
    wr(A_IVAL, 3);
    idle(300);
    rd(A_STAT, r);
    chk(r[BUSY_B] == 1, "R9", "reserved source stays busy", r[BUSY_B], 1);
    chk(r[FLAG_B] == 0, "R9", "reserved source no flag", r[FLAG_B], 0);
    wr(A_CTRL, ARM | IE | (32'd1 << 12));
    wr(A_CTRL, ARM | IE);
    wr(A_CTRL, RUN | ARM | IE);
    wait_idle(300, ok); chk(ok, "R9", "transfer completes on valid source", ok, 1);
    wait_flag(300, seen); chk(seen, "R9", "counting resumes", seen, 1);
    disarm();

    done = 1;
    summary();
    $finish;
  end
endmodule